// File: doc/BRIEF.md
# Codec Register Access Controller

This block sits between a host register port and the command/status slots of a serial audio codec link. The host writes a 32-bit control word naming a codec register, the direction and, for writes, the data, and it sets a pending bit in the same word. At the next frame boundary the block puts the command into the outgoing command slot and clears the pending bit. The host polls the pending bit to learn that the command has left. For reads, the codec answers in a later frame with a status slot tagged with the register address. The block keeps that slot, and when the tag matches the outstanding read it raises a fresh-status flag that the host polls.

The same handshake carries a warm link reset request. The control word also holds link shutdown and per-codec power-down levels, which drive outputs directly. Two codec-ready inputs are synchronised and appear in the status word. The serial bit timing of the link is abstracted as a one-cycle frame strobe plus parallel slot words.

Top module: `codec_reg_access_ctl`

## Requirements
- R1: After reset the control readback is zero, the status fresh flag (bit 17) is zero, and neither `slot_cmd_vld` nor `link_warm_rst` is asserted.
- R2: A control write (host_sel=0) accepted while no command is pending stores the word exactly, and reads back unchanged. Layout: bit 31 read, bits 30:24 register address, bit 21 primary power-down, bit 20 secondary power-down, bit 18 shutdown, bit 17 warm reset, bit 16 pending, bits 15:0 data. All other bits read as written.
- R3: With pending set, the first clock edge that sees `frame_strobe` high makes `slot_cmd_vld` high for exactly the next cycle, carrying bit 31, bits 30:24 and bits 15:0 on `slot_cmd_rd`, `slot_cmd_addr` and `slot_cmd_data`. In that same cycle the pending bit reads back as 0.
- R4: No command leaves without a frame strobe, and each pending command leaves exactly once. Later strobes produce nothing until a new command is written.
- R5: A control write made while the pending bit is still set is ignored entirely, and the control readback keeps its old value.
- R6: When bits 17 and 16 are both set, the next frame strobe produces a one-cycle `link_warm_rst` pulse instead of a command slot. Bits 17 and 16 then both read back as 0.
- R7: Every valid status slot is stored. Its tag appears in status bits 31:24 and its data in status bits 15:0 from the cycle after it arrives.
- R8: The fresh flag (status bit 17) is set only by a status slot whose 8-bit tag equals {1'b0, address} of the most recent read command sent and not yet answered. Mismatched tags, and slots arriving when no read is outstanding, leave it at 0.
- R9: Reading the status register (host_rd with host_sel=1) clears the fresh flag at the next edge. If a matching slot arrives in the same cycle, the flag stays set.
- R10: `codec_rdy_pri` and `codec_rdy_sec` appear in status bits 23 and 22 after SYNC_STAGES clock edges.
- R11: Control bits 18, 21 and 20 drive `link_shutdown`, `pwrdn_pri` and `pwrdn_sec`. A write with these bits and pending clear sends nothing on the link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (clears fresh flag on status) |
| host_sel | input | 1 | 0 = control register, 1 = status register |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data of the selected register |
| frame_strobe | input | 1 | One-cycle mark of a link frame boundary |
| slot_cmd_vld | output | 1 | Command slot valid this cycle |
| slot_cmd_rd | output | 1 | Command is a read |
| slot_cmd_addr | output | 7 | Codec register address |
| slot_cmd_data | output | 16 | Command data |
| link_warm_rst | output | 1 | Warm link reset pulse |
| link_shutdown | output | 1 | Link shutdown level |
| pwrdn_pri | output | 1 | Primary codec power-down level |
| pwrdn_sec | output | 1 | Secondary codec power-down level |
| slot_sts_vld | input | 1 | Status slot valid |
| slot_sts_tag | input | 8 | Status slot register tag |
| slot_sts_data | input | 16 | Status slot data |
| codec_rdy_pri | input | 1 | Primary codec ready (asynchronous) |
| codec_rdy_sec | input | 1 | Secondary codec ready (asynchronous) |

## Verification
The hardest case is a matching status slot that arrives in the same cycle as the host read that would clear the fresh flag. Reaching it requires a read command to be sent first and left unanswered. The stimulus sends a read, holds back the answer, and then drives the slot and the status read on the same edge. A second hard case is an outstanding read that first receives a wrong tag. A later correct tag must still raise the flag, and the stimulus sends both in turn. Randomised rounds mix read and write commands, random addresses, data and link-level bits, and include occasional mismatched tags.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;

    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 7;
    localparam int TAG_W   = 8;
    localparam int DATA_W  = 16;
    localparam int NUM_RDY = 2;

    // Control word; field positions are the host's programming contract.
    typedef struct packed {
        logic              rd;        // 31
        logic [ADDR_W-1:0] addr;      // 30:24
        logic [1:0]        spare_hi;  // 23:22
        logic              pd_pri;    // 21
        logic              pd_sec;    // 20
        logic              spare_mid; // 19
        logic              shut;      // 18
        logic              warm;      // 17
        logic              pend;      // 16
        logic [DATA_W-1:0] data;      // 15:0
    } ctrl_t;

    // Status word presented to the host.
    typedef struct packed {
        logic [TAG_W-1:0]  tag;       // 31:24
        logic              rdy_pri;   // 23
        logic              rdy_sec;   // 22
        logic [3:0]        zero_a;    // 21:18
        logic              fresh;     // 17
        logic              zero_b;    // 16
        logic [DATA_W-1:0] data;      // 15:0
    } status_t;

    // Outgoing command slot.
    typedef struct packed {
        logic              vld;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_slot_t;

    function automatic status_t build_status(
        input logic [TAG_W-1:0]  tag,
        input logic [NUM_RDY-1:0] rdy,
        input logic              fresh,
        input logic [DATA_W-1:0] data
    );
        status_t s;
        s         = '0;
        s.tag     = tag;
        s.rdy_pri = rdy[0];
        s.rdy_sec = rdy[1];
        s.fresh   = fresh;
        s.data    = data;
        return s;
    endfunction

    function automatic logic tag_hits(
        input logic [TAG_W-1:0]  tag,
        input logic [ADDR_W-1:0] addr
    );
        return tag == {{(TAG_W-ADDR_W){1'b0}}, addr};
    endfunction

endpackage

// File: rtl/codec_cmd_reg.sv
module codec_cmd_reg
    import codec_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  ctrl_t     wr_word,
    input  logic      frame_strobe,
    output ctrl_t     ctrl_q,
    output cmd_slot_t slot_q,
    output logic      warm_q
);

    logic launch;
    assign launch = ctrl_q.pend && frame_strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            slot_q <= '0;
            warm_q <= 1'b0;
        end else begin
            slot_q.vld <= 1'b0;
            warm_q     <= 1'b0;
            if (launch) begin
                if (ctrl_q.warm) begin
                    warm_q <= 1'b1;
                end else begin
                    slot_q.vld  <= 1'b1;
                    slot_q.rd   <= ctrl_q.rd;
                    slot_q.addr <= ctrl_q.addr;
                    slot_q.data <= ctrl_q.data;
                end
                ctrl_q.pend <= 1'b0;
                ctrl_q.warm <= 1'b0;
            end else if (wr_en && !ctrl_q.pend) begin
                ctrl_q <= wr_word;
            end
        end
    end

endmodule

// File: rtl/codec_status_cap.sv
module codec_status_cap
    import codec_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_slot_t         sent,
    input  logic              sts_vld,
    input  logic [TAG_W-1:0]  sts_tag,
    input  logic [DATA_W-1:0] sts_data,
    input  logic              host_clr,
    output logic [TAG_W-1:0]  tag_q,
    output logic [DATA_W-1:0] data_q,
    output logic              fresh_q
);

    logic              await_q;
    logic [ADDR_W-1:0] want_q;
    logic              hit;

    assign hit = sts_vld && await_q && tag_hits(sts_tag, want_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q   <= '0;
            data_q  <= '0;
            fresh_q <= 1'b0;
            await_q <= 1'b0;
            want_q  <= '0;
        end else begin
            if (sts_vld) begin
                tag_q  <= sts_tag;
                data_q <= sts_data;
            end
            if (hit)
                fresh_q <= 1'b1;
            else if (host_clr)
                fresh_q <= 1'b0;
            if (sent.vld && sent.rd) begin
                await_q <= 1'b1;
                want_q  <= sent.addr;
            end else if (hit) begin
                await_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/codec_rdy_sync.sv
module codec_rdy_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign dout = din;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] pipe;
            for (genvar s = 0; s < STAGES; s++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst)
                        pipe[s] <= '0;
                    else if (s == 0)
                        pipe[s] <= din;
                    else
                        pipe[s] <= pipe[(s == 0) ? 0 : s-1];
                end
            end
            assign dout = pipe[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/codec_reg_access_ctl.sv
module codec_reg_access_ctl
    import codec_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic        host_sel,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    input  logic        frame_strobe,
    output logic        slot_cmd_vld,
    output logic        slot_cmd_rd,
    output logic [6:0]  slot_cmd_addr,
    output logic [15:0] slot_cmd_data,
    output logic        link_warm_rst,
    output logic        link_shutdown,
    output logic        pwrdn_pri,
    output logic        pwrdn_sec,
    input  logic        slot_sts_vld,
    input  logic [7:0]  slot_sts_tag,
    input  logic [15:0] slot_sts_data,
    input  logic        codec_rdy_pri,
    input  logic        codec_rdy_sec
);

    ctrl_t             ctrl_q;
    cmd_slot_t         slot_q;
    logic              warm_q;
    logic [TAG_W-1:0]  sts_tag_q;
    logic [DATA_W-1:0] sts_data_q;
    logic              sts_fresh;
    logic [NUM_RDY-1:0] rdy_s;
    logic              ctrl_wr;
    logic              sts_clr;
    status_t           sts_word;

    assign ctrl_wr = host_wr && !host_sel;
    assign sts_clr = host_rd && host_sel;

    codec_cmd_reg u_cmd (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (ctrl_wr),
        .wr_word      (ctrl_t'(host_wdata)),
        .frame_strobe (frame_strobe),
        .ctrl_q       (ctrl_q),
        .slot_q       (slot_q),
        .warm_q       (warm_q)
    );

    codec_status_cap u_sts (
        .clk      (clk),
        .rst      (rst),
        .sent     (slot_q),
        .sts_vld  (slot_sts_vld),
        .sts_tag  (slot_sts_tag),
        .sts_data (slot_sts_data),
        .host_clr (sts_clr),
        .tag_q    (sts_tag_q),
        .data_q   (sts_data_q),
        .fresh_q  (sts_fresh)
    );

    codec_rdy_sync #(
        .WIDTH  (NUM_RDY),
        .STAGES (SYNC_STAGES)
    ) u_rdy (
        .clk  (clk),
        .rst  (rst),
        .din  ({codec_rdy_sec, codec_rdy_pri}),
        .dout (rdy_s)
    );

    assign sts_word   = build_status(sts_tag_q, rdy_s, sts_fresh, sts_data_q);
    assign host_rdata = host_sel ? 32'(sts_word) : 32'(ctrl_q);

    assign slot_cmd_vld  = slot_q.vld;
    assign slot_cmd_rd   = slot_q.rd;
    assign slot_cmd_addr = slot_q.addr;
    assign slot_cmd_data = slot_q.data;
    assign link_warm_rst = warm_q;
    assign link_shutdown = ctrl_q.shut;
    assign pwrdn_pri     = ctrl_q.pd_pri;
    assign pwrdn_sec     = ctrl_q.pd_sec;

endmodule

// File: rtl/codec_reg_access_chk.sv
module codec_reg_access_chk (
    input logic        clk,
    input logic        rst,
    input logic        frame_strobe,
    input logic        host_rd,
    input logic        host_sel,
    input logic        slot_cmd_vld,
    input logic        link_warm_rst,
    input logic        cmd_pend,
    input logic        fresh,
    input logic [31:0] ctrl_word
);

    // R3
    launch_at_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_cmd_vld || link_warm_rst) |-> ($past(frame_strobe) && $past(cmd_pend)));

    // R3
    pend_drops_on_send_chk: assert property (@(posedge clk) disable iff (rst)
        slot_cmd_vld |-> !cmd_pend);

    // R6
    warm_or_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        !(slot_cmd_vld && link_warm_rst));

    // R5
    word_held_while_pend_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd_pend) && !$past(frame_strobe)) |-> $stable(ctrl_word));

    // R9
    fresh_falls_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fresh) |-> $past(host_rd && host_sel));

endmodule

bind codec_reg_access_ctl codec_reg_access_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .frame_strobe  (frame_strobe),
    .host_rd       (host_rd),
    .host_sel      (host_sel),
    .slot_cmd_vld  (slot_cmd_vld),
    .link_warm_rst (link_warm_rst),
    .cmd_pend      (ctrl_q.pend),
    .fresh         (sts_fresh),
    .ctrl_word     (32'(ctrl_q))
);

// File: tb/tb_codec_reg_access_ctl.sv
`timescale 1ns/1ps
module tb_codec_reg_access_ctl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0, host_rd = 1'b0, host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        frame_strobe = 1'b0;
    logic        slot_cmd_vld, slot_cmd_rd;
    logic [6:0]  slot_cmd_addr;
    logic [15:0] slot_cmd_data;
    logic        link_warm_rst, link_shutdown, pwrdn_pri, pwrdn_sec;
    logic        slot_sts_vld = 1'b0;
    logic [7:0]  slot_sts_tag = '0;
    logic [15:0] slot_sts_data = '0;
    logic        codec_rdy_pri = 1'b0, codec_rdy_sec = 1'b0;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    codec_reg_access_ctl dut (.*);

    function automatic logic [31:0] mk_ctrl(input logic rd, input logic [6:0] a,
        input logic [15:0] d, input logic pend, input logic warm,
        input logic shut, input logic pdp, input logic pds);
        return {rd, a, 2'b00, pdp, pds, 1'b0, shut, warm, pend, d};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [31:0] w);
        @(negedge clk); host_wr = 1; host_sel = 0; host_wdata = w;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic peek(input logic sel, output logic [31:0] v);
        host_sel = sel; host_rd = 0; #1 v = host_rdata;
    endtask

    task automatic rd_status(output logic [31:0] v);
        @(negedge clk); host_sel = 1; host_rd = 1; #1 v = host_rdata;
        @(negedge clk); host_rd = 0;
    endtask

    task automatic strobe();
        @(negedge clk); frame_strobe = 1;
        @(negedge clk); frame_strobe = 0;
    endtask

    task automatic send_sts(input logic [7:0] t, input logic [15:0] d);
        @(negedge clk); slot_sts_vld = 1; slot_sts_tag = t; slot_sts_data = d;
        @(negedge clk); slot_sts_vld = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, w;
        logic exp_await, exp_fresh;
        logic [6:0] exp_want;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        peek(0, v); check(v == 0, "R1 ctrl", v, 0);
        peek(1, v); check(v[17] == 0, "R1 fresh", v, 0);
        check(!slot_cmd_vld && !link_warm_rst, "R1 pulses",
              {slot_cmd_vld, link_warm_rst}, 0);

        // R2 write and readback
        w = mk_ctrl(1, 7'h26, 16'hBEEF, 1, 0, 0, 0, 0) | 32'h00C8_0000;
        wr_ctrl(w);
        peek(0, v); check(v == w, "R2 readback", v, w);

        // R4 no launch without strobe
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); peek(0, v);
            check(!slot_cmd_vld && v[16], "R4 idle no launch", {slot_cmd_vld, v[16]}, 1);
        end

        // R5 write while pending ignored
        wr_ctrl(mk_ctrl(0, 7'h11, 16'h1234, 1, 0, 1, 1, 1));
        peek(0, v); check(v == w, "R5 ignored", v, w);
        check(!link_shutdown && !pwrdn_pri, "R5 outputs unchanged",
              {link_shutdown, pwrdn_pri}, 0);

        // R3 launch
        strobe();
        check(slot_cmd_vld && slot_cmd_rd && slot_cmd_addr == 7'h26 &&
              slot_cmd_data == 16'hBEEF, "R3 slot",
              {slot_cmd_vld, slot_cmd_rd, slot_cmd_addr, slot_cmd_data},
              {1'b1, 1'b1, 7'h26, 16'hBEEF});
        peek(0, v); check(v[16] == 0, "R3 pend cleared", v, w & ~32'h10000);
        @(negedge clk);
        check(!slot_cmd_vld, "R3 one cycle", slot_cmd_vld, 0);
        strobe();
        check(!slot_cmd_vld, "R4 single launch", slot_cmd_vld, 0);

        // R8 mismatched tag keeps flag low, R7 capture
        send_sts(8'h27, 16'h5555);
        peek(1, v);
        check(v[31:24] == 8'h27 && v[15:0] == 16'h5555, "R7 capture", v, 32'h2700_5555);
        check(v[17] == 0, "R8 mismatch", v[17], 0);
        send_sts(8'h26, 16'hA5A5);
        rd_status(v);
        check(v[17] == 1 && v[31:24] == 8'h26 && v[15:0] == 16'hA5A5, "R8 match",
              v, 32'h2602_A5A5);
        peek(1, v); check(v[17] == 0, "R9 cleared by read", v[17], 0);
        send_sts(8'h26, 16'h0001);
        peek(1, v); check(v[17] == 0, "R8 no outstanding read", v[17], 0);

        // R9 set wins over clear
        wr_ctrl(mk_ctrl(1, 7'h05, 16'h0, 1, 0, 0, 0, 0));
        strobe();
        @(negedge clk);
        host_sel = 1; host_rd = 1; slot_sts_vld = 1; slot_sts_tag = 8'h05;
        slot_sts_data = 16'h7777;
        @(negedge clk);
        host_rd = 0; slot_sts_vld = 0;
        peek(1, v); check(v[17] == 1, "R9 set wins", v[17], 1);
        rd_status(v);

        // R6 warm reset
        wr_ctrl(mk_ctrl(0, 7'h00, 16'h0, 1, 1, 0, 0, 0));
        strobe();
        check(link_warm_rst && !slot_cmd_vld, "R6 warm pulse",
              {link_warm_rst, slot_cmd_vld}, 2'b10);
        peek(0, v); check(v[17:16] == 2'b00, "R6 bits clear", v, 0);
        @(negedge clk);
        check(!link_warm_rst, "R6 one cycle", link_warm_rst, 0);

        // R10 ready sync
        @(negedge clk); codec_rdy_pri = 1; codec_rdy_sec = 1;
        @(negedge clk); peek(1, v);
        check(v[23:22] == 2'b00, "R10 not yet", v[23:22], 0);
        @(negedge clk); peek(1, v);
        check(v[23:22] == 2'b11, "R10 ready", v[23:22], 2'b11);

        // R11 level controls without pending
        wr_ctrl(mk_ctrl(0, 7'h3, 16'h9, 0, 0, 1, 1, 0));
        check(link_shutdown && pwrdn_pri && !pwrdn_sec, "R11 levels",
              {link_shutdown, pwrdn_pri, pwrdn_sec}, 3'b110);
        strobe();
        check(!slot_cmd_vld, "R11 no send", slot_cmd_vld, 0);

        // Random rounds (R2 R3 R7 R8 R9 R11)
        exp_await = 0; exp_want = 0; exp_fresh = 0;
        for (int k = 0; k < 40; k++) begin
            logic rd, sh, pp, ps;
            logic [6:0] a;
            logic [15:0] d, sd;
            logic [7:0] t;
            rd = 1'($urandom); a = 7'($urandom); d = 16'($urandom);
            sh = 1'($urandom); pp = 1'($urandom); ps = 1'($urandom);
            w = mk_ctrl(rd, a, d, 1, 0, sh, pp, ps);
            wr_ctrl(w);
            peek(0, v); check(v == w, "R2 random readback", v, w);
            check(link_shutdown == sh && pwrdn_pri == pp && pwrdn_sec == ps,
                  "R11 random", {link_shutdown, pwrdn_pri, pwrdn_sec}, {sh, pp, ps});
            repeat ($urandom % 3) @(negedge clk);
            strobe();
            check(slot_cmd_vld && slot_cmd_rd == rd && slot_cmd_addr == a &&
                  slot_cmd_data == d, "R3 random slot",
                  {slot_cmd_vld, slot_cmd_rd, slot_cmd_addr, slot_cmd_data},
                  {1'b1, rd, a, d});
            if (rd) begin
                exp_await = 1; exp_want = a;
                t = ($urandom % 4 == 0) ? {1'b1, a} : {1'b0, a};
                sd = 16'($urandom);
                send_sts(t, sd);
                if (exp_await && t == {1'b0, exp_want}) begin
                    exp_fresh = 1; exp_await = 0;
                end
                rd_status(v);
                check(v[31:24] == t && v[15:0] == sd, "R7 random capture",
                      v, {t, 8'h0, sd});
                check(v[17] == exp_fresh, "R8 random flag", v[17], exp_fresh);
                exp_fresh = 0;
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule